// File: doc/BRIEF.md
# Fixed-Priority Speculative Memory Arbiter

This block decides which of three requesters gets the memory sequencer for its next cycle. The three are the I/O-bus slave engine, the refresh counter and the CPU. The clock is a phase clock, with four phases to a 200 ns microcycle. An idle cycle lasts one microcycle and a memory cycle lasts two. Requests are looked at only in the last phase of a cycle, and the winner's cycle begins on the following edge. The slave engine ranks first, the refresh counter second and the CPU last.

When no slave or refresh request is waiting, the arbiter does not wait for the CPU. It starts a CPU cycle on the microcycle boundary, before the CPU has shown its address strobe. In the fourth phase of that cycle it looks at the strobe. If the strobe is high, the cycle goes on and the DRAM strobes are released. If the strobe is low, the cycle is killed at once without touching the DRAM, and a new poll is taken on the same edge.

A CPU read-lock works as follows. Any slave request that is already waiting is served first. The arbiter then stalls the CPU and asks the bus arbitration logic to hold the bus for it. While it waits for mastership, it still serves refresh and slave cycles. Once mastership is granted, the stall is released and the locked CPU accesses run. The bus hold stays raised until a CPU cycle marked as the write/unlock has completed.

Top module: `specMemArbiter`

## Requirements
- R1: During reset and for the first four phases after reset is released, no grant, stall or bus hold is active, and `seqEnable`, `dramGo` and `seqKill` are low.
- R2: Requests are sampled only in the last phase of a cycle. A request that is raised and then dropped again inside a memory cycle does not affect the next grant.
- R3: At a poll, a waiting slave request wins over a waiting refresh request, and both win over the CPU.
- R4: At a poll with no slave or refresh request, and with no lock wait in progress, a speculative CPU cycle begins. `grantCpu` and `seqEnable` are high from its first phase, and `dramGo` is low.
- R5: In phase index 3 of a speculative CPU cycle, the CPU address strobe is checked. If it is high, `dramGo` is high in phases 4 to 7 and `doneCpu` pulses in phase 7. If it is low, `seqKill` pulses in phase 3, `dramGo` stays low, no done pulse is given, and the next poll happens in that same phase.
- R6: A slave or refresh cycle shows its grant and `dramGo` from the phase right after the poll, lasts 8 phases, and pulses its done signal only in its last phase.
- R7: When `cpuLockReq` is high and a slave request is waiting, the slave is served first with no stall. At the first poll with no slave request, `cpuStall` and `busHoldReq` go high.
- R8: While `cpuStall` is high, the CPU is never granted. Refresh and slave requests are still granted, and with no request an idle cycle (no grant) runs.
- R9: At a poll during the stall with `busMasterAck` high, `cpuStall` drops and a CPU cycle begins. `busHoldReq` stays high until a CPU cycle completes that had `cpuUnlock` high when its strobe was checked. It is low from the phase after that cycle's done pulse.
- R10: At most one grant is active, and each done pulse lasts a single phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rstN | input | 1 | Active-low synchronous reset |
| slaveReq | input | 1 | I/O-bus slave engine wants a memory cycle |
| refreshReq | input | 1 | Refresh counter wants a refresh cycle |
| cpuAddrStrobe | input | 1 | CPU address strobe, checked in phase 3 of a CPU cycle |
| cpuUnlock | input | 1 | Marks the CPU access as the write/unlock, sampled with the strobe |
| cpuLockReq | input | 1 | CPU asks for a read-lock |
| busMasterAck | input | 1 | Bus arbitration logic reports that mastership has been gained |
| grantSlave | output | 1 | Current cycle belongs to the slave engine |
| grantRefresh | output | 1 | Current cycle belongs to the refresh counter |
| grantCpu | output | 1 | Current cycle belongs to the CPU, speculative or committed |
| seqEnable | output | 1 | Sequencer is enabled for a cycle |
| seqKill | output | 1 | Speculative CPU cycle is cancelled in this phase |
| dramGo | output | 1 | Sequencer may drive DRAM strobes |
| doneSlave | output | 1 | Single-phase completion pulse for the slave engine |
| doneRefresh | output | 1 | Single-phase completion pulse for the refresh counter |
| doneCpu | output | 1 | Single-phase completion pulse for the CPU |
| cpuStall | output | 1 | CPU is held while the lock waits for bus mastership |
| busHoldReq | output | 1 | Request to the bus arbitration logic to hold the bus |

## Verification
The bench uses the default parameters: four phases per microcycle, two microcycles per memory cycle, and the strobe check in phase 3. With these values a killed speculative cycle is exactly as long as an idle cycle. The back-to-back killed CPU cycles, the 8-phase slave and refresh cycles, and a full lock sequence (slave first, waiting with refresh and slave service, a locked read, then the unlock) all fit in a few hundred phases. Every phase on which a result is expected lies a short, fixed distance from a visible poll, so each grant, kill and done pulse is checked in its exact phase.

// File: rtl/memArbPkg.sv
package memArbPkg;

  typedef enum logic [1:0] {
    CK_IDLE    = 2'd0,
    CK_SLAVE   = 2'd1,
    CK_REFRESH = 2'd2,
    CK_CPU     = 2'd3
  } cycKind_t;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_WAIT = 2'd1,
    LK_HELD = 2'd2
  } lockSt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     launch;
    cycKind_t launchKind;
    logic     commit;
    logic     kill;
  } ctlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    cycKind_t kind;
    logic     committed;
    logic     unlockSeen;
    logic     atIdleEnd;
    logic     atCheck;
    logic     atMemEnd;
  } dpStatus_t;

endpackage

// File: rtl/memArbDatapath.sv
module memArbDatapath
  import memArbPkg::*;
#(
  parameter int PH_PER_MICRO = 4,
  parameter int MEM_MICROS   = 2,
  parameter int CHECK_PHASE  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuUnlock,
  input  ctlStrobes_t strobes,
  output dpStatus_t   status,
  output logic        grantSlave,
  output logic        grantRefresh,
  output logic        grantCpu,
  output logic        seqEnable,
  output logic        seqKill,
  output logic        dramGo,
  output logic        doneSlave,
  output logic        doneRefresh,
  output logic        doneCpu
);

  localparam int MEM_LEN = PH_PER_MICRO * MEM_MICROS;
  localparam int CNT_W   = (MEM_LEN > 2) ? $clog2(MEM_LEN) : 1;
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(PH_PER_MICRO - 1);
  localparam logic [CNT_W-1:0] MEM_LAST  = CNT_W'(MEM_LEN - 1);
  localparam logic [CNT_W-1:0] CHECK_AT  = CNT_W'(CHECK_PHASE);

  logic [CNT_W-1:0] phaseCnt;
  cycKind_t         curKind;
  logic             committed;
  logic             unlockSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt   <= '0;
      curKind    <= CK_IDLE;
      committed  <= 1'b0;
      unlockSeen <= 1'b0;
    end else if (strobes.launch) begin
      phaseCnt   <= '0;
      curKind    <= strobes.launchKind;
      committed  <= (strobes.launchKind == CK_SLAVE) ||
                    (strobes.launchKind == CK_REFRESH);
      unlockSeen <= 1'b0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
      if (strobes.commit) begin
        committed  <= 1'b1;
        unlockSeen <= cpuUnlock;
      end
    end
  end

  always_comb begin
    status.kind       = curKind;
    status.committed  = committed;
    status.unlockSeen = unlockSeen;
    status.atIdleEnd  = (curKind == CK_IDLE) && (phaseCnt == IDLE_LAST);
    status.atCheck    = (curKind == CK_CPU) && !committed && (phaseCnt == CHECK_AT);
    status.atMemEnd   = committed && (phaseCnt == MEM_LAST);
  end

  always_comb begin
    grantSlave   = (curKind == CK_SLAVE);
    grantRefresh = (curKind == CK_REFRESH);
    grantCpu     = (curKind == CK_CPU);
    seqEnable    = (curKind != CK_IDLE);
    seqKill      = strobes.kill;
    dramGo       = committed;
    doneSlave    = status.atMemEnd && (curKind == CK_SLAVE);
    doneRefresh  = status.atMemEnd && (curKind == CK_REFRESH);
    doneCpu      = status.atMemEnd && (curKind == CK_CPU);
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneSlave || doneRefresh || doneCpu) |=> !(doneSlave || doneRefresh || doneCpu)); // R10

  AST_SPEC_NO_DRAM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantCpu) |-> !dramGo); // R4

endmodule

// File: rtl/memArbControl.sv
module memArbControl
  import memArbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        slaveReq,
  input  logic        refreshReq,
  input  logic        cpuAddrStrobe,
  input  logic        cpuLockReq,
  input  logic        busMasterAck,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        cpuStall,
  output logic        busHoldReq
);

  lockSt_t  lockState;
  lockSt_t  nextLock;
  lockSt_t  lockAfter;
  cycKind_t decision;
  logic     pollNow;
  logic     unlockDone;

  always_comb begin
    strobes.commit = status.atCheck && cpuAddrStrobe;
    strobes.kill   = status.atCheck && !cpuAddrStrobe;
    pollNow        = status.atIdleEnd || strobes.kill || status.atMemEnd;
    unlockDone     = (lockState == LK_HELD) && status.atMemEnd && status.committed &&
                     (status.kind == CK_CPU) && status.unlockSeen;
  end

  always_comb begin
    lockAfter = unlockDone ? LK_NONE : lockState;
    nextLock  = lockAfter;
    decision  = CK_IDLE;
    if (slaveReq) begin
      decision = CK_SLAVE;
    end else begin
      if ((lockAfter == LK_NONE) && cpuLockReq) nextLock = LK_WAIT;
      if (refreshReq) begin
        decision = CK_REFRESH;
      end else if (nextLock == LK_WAIT) begin
        if (busMasterAck) begin
          nextLock = LK_HELD;
          decision = CK_CPU;
        end
      end else begin
        decision = CK_CPU;
      end
    end
    strobes.launch     = pollNow;
    strobes.launchKind = decision;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockState <= LK_NONE;
    else if (pollNow) lockState <= nextLock;
  end

  assign cpuStall   = (lockState == LK_WAIT);
  assign busHoldReq = (lockState != LK_NONE);

  AST_SLAVE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (pollNow && slaveReq) |=> (status.kind == CK_SLAVE)); // R3

  AST_STALL_NO_CPU: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> (status.kind != CK_CPU)); // R8

  AST_HOLD_TILL_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busHoldReq) |-> $past(status.atMemEnd && (status.kind == CK_CPU) && status.unlockSeen)); // R9

endmodule

// File: rtl/specMemArbiter.sv
module specMemArbiter
  import memArbPkg::*;
#(
  parameter int PH_PER_MICRO = 4,
  parameter int MEM_MICROS   = 2,
  parameter int CHECK_PHASE  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic slaveReq,
  input  logic refreshReq,
  input  logic cpuAddrStrobe,
  input  logic cpuUnlock,
  input  logic cpuLockReq,
  input  logic busMasterAck,
  output logic grantSlave,
  output logic grantRefresh,
  output logic grantCpu,
  output logic seqEnable,
  output logic seqKill,
  output logic dramGo,
  output logic doneSlave,
  output logic doneRefresh,
  output logic doneCpu,
  output logic cpuStall,
  output logic busHoldReq
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  memArbControl u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .slaveReq      (slaveReq),
    .refreshReq    (refreshReq),
    .cpuAddrStrobe (cpuAddrStrobe),
    .cpuLockReq    (cpuLockReq),
    .busMasterAck  (busMasterAck),
    .status        (status),
    .strobes       (strobes),
    .cpuStall      (cpuStall),
    .busHoldReq    (busHoldReq)
  );

  memArbDatapath #(
    .PH_PER_MICRO (PH_PER_MICRO),
    .MEM_MICROS   (MEM_MICROS),
    .CHECK_PHASE  (CHECK_PHASE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cpuUnlock    (cpuUnlock),
    .strobes      (strobes),
    .status       (status),
    .grantSlave   (grantSlave),
    .grantRefresh (grantRefresh),
    .grantCpu     (grantCpu),
    .seqEnable    (seqEnable),
    .seqKill      (seqKill),
    .dramGo       (dramGo),
    .doneSlave    (doneSlave),
    .doneRefresh  (doneRefresh),
    .doneCpu      (doneCpu)
  );

  AST_STROBE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dramGo) && grantCpu) |-> $past(cpuAddrStrobe)); // R5

endmodule

// File: tb/specMemArbiter_tb.sv
module specMemArbiter_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveReq = 1'b0, refreshReq = 1'b0, cpuAddrStrobe = 1'b0;
  logic cpuUnlock = 1'b0, cpuLockReq = 1'b0, busMasterAck = 1'b0;
  logic grantSlave, grantRefresh, grantCpu, seqEnable, seqKill, dramGo;
  logic doneSlave, doneRefresh, doneCpu, cpuStall, busHoldReq;

  int checks = 0;
  int fails = 0;
  int expQ[$];

  always #10 clk = ~clk;

  specMemArbiter u_dut (
    .clk(clk), .rstN(rstN), .slaveReq(slaveReq), .refreshReq(refreshReq),
    .cpuAddrStrobe(cpuAddrStrobe), .cpuUnlock(cpuUnlock), .cpuLockReq(cpuLockReq),
    .busMasterAck(busMasterAck), .grantSlave(grantSlave), .grantRefresh(grantRefresh),
    .grantCpu(grantCpu), .seqEnable(seqEnable), .seqKill(seqKill), .dramGo(dramGo),
    .doneSlave(doneSlave), .doneRefresh(doneRefresh), .doneCpu(doneCpu),
    .cpuStall(cpuStall), .busHoldReq(busHoldReq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // event codes: 1 slave done, 2 refresh done, 3 cpu done, 4 kill
  always @(negedge clk) begin
    if (rstN && (doneSlave || doneRefresh || doneCpu || seqKill)) begin
      int code;
      code = doneSlave ? 1 : doneRefresh ? 2 : doneCpu ? 3 : 4;
      chk($countones({doneSlave, doneRefresh, doneCpu, seqKill}) == 1, "R10 one event",
          $countones({doneSlave, doneRefresh, doneCpu, seqKill}), 1);
      chk($countones({grantSlave, grantRefresh, grantCpu}) == 1, "R10 one grant",
          $countones({grantSlave, grantRefresh, grantCpu}), 1);
      if (expQ.size() == 0) chk(1'b0, "R5/R6 unexpected event", code, 0);
      else begin
        int e;
        e = expQ.pop_front();
        chk(code == e, "R5/R6 event order", code, e);
      end
    end
  end

  // starts at a poll phase; started=1 means the CPU cycle is already in phase 0
  task automatic runCpu(input bit strobe, input bit unlock, input bit started);
    expQ.push_back(strobe ? 3 : 4);
    if (!started) begin
      @(negedge clk);
      chk(grantCpu && !dramGo && seqEnable, "R4 speculative start", {grantCpu, dramGo}, 2);
    end
    tick(2);
    cpuAddrStrobe = strobe;
    cpuUnlock = unlock;
    @(negedge clk);
    chk(seqKill == !strobe, "R5 kill decision", seqKill, !strobe);
    chk(!dramGo, "R5 no dram before check", dramGo, 0);
    if (strobe) begin
      @(negedge clk);
      cpuAddrStrobe = 1'b0;
      cpuUnlock = 1'b0;
      chk(dramGo, "R5 dram after commit", dramGo, 1);
      tick(2);
      chk(!doneCpu, "R5 no early done", doneCpu, 0);
      @(negedge clk);
      chk(doneCpu, "R5 done in phase 7", doneCpu, 1);
    end
  endtask

  // sel 1 slave, 2 refresh; starts and ends at a poll phase
  task automatic serve(input int sel, input bit glitch);
    if (sel == 1) slaveReq = 1'b1; else refreshReq = 1'b1;
    expQ.push_back(sel);
    @(negedge clk);
    if (sel == 1) begin
      chk(grantSlave && dramGo, "R6 slave grant", {grantSlave, dramGo}, 3);
      slaveReq = 1'b0;
    end else begin
      chk(grantRefresh && dramGo, "R6 refresh grant", {grantRefresh, dramGo}, 3);
      refreshReq = 1'b0;
    end
    tick(2);
    if (glitch) refreshReq = 1'b1;
    tick(2);
    if (glitch) refreshReq = 1'b0;
    tick(2);
    chk(!(doneSlave || doneRefresh), "R6 no early done", doneSlave | doneRefresh, 0);
    @(negedge clk);
    chk(sel == 1 ? doneSlave : doneRefresh, "R6 done in last phase",
        sel == 1 ? doneSlave : doneRefresh, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    chk(!grantSlave && !grantRefresh && !grantCpu && !seqEnable && !cpuStall && !busHoldReq,
        "R1 reset outputs", {grantSlave, grantRefresh, grantCpu, seqEnable}, 0);
    rstN = 1'b1;
    tick(1);
    chk(!seqEnable && !dramGo, "R1 idle after reset", seqEnable, 0);
    tick(2);
    chk(!seqEnable && !seqKill && !cpuStall, "R1 idle fourth phase", seqEnable, 0);

    // killed and committed speculative cycles
    runCpu(1'b0, 1'b0, 1'b0);
    runCpu(1'b0, 1'b0, 1'b0);
    runCpu(1'b1, 1'b0, 1'b0);
    runCpu(1'b1, 1'b0, 1'b0);

    // R3 priority: slave over refresh, then refresh over CPU
    refreshReq = 1'b1;
    serve(1, 1'b0);
    serve(2, 1'b0);
    runCpu(1'b0, 1'b0, 1'b0);

    // R2 mid-cycle refresh pulse is not seen at the next poll
    serve(1, 1'b1);
    expQ.push_back(4);
    @(negedge clk);
    chk(grantCpu && !grantRefresh, "R2 mid-cycle request ignored", {grantRefresh, grantCpu}, 1);
    tick(3);

    // R7 lock: pending slave first
    cpuLockReq = 1'b1;
    serve(1, 1'b0);
    chk(!cpuStall && !busHoldReq, "R7 no stall while slave served", cpuStall, 0);
    @(negedge clk);
    chk(cpuStall && busHoldReq && !seqEnable, "R7 stall and hold", {cpuStall, busHoldReq, seqEnable}, 6);
    tick(3);
    chk(!seqEnable && !grantCpu, "R8 idle while stalled", seqEnable, 0);
    serve(2, 1'b0);
    chk(cpuStall, "R8 refresh served during stall", cpuStall, 1);
    tick(4);
    chk(!grantCpu && cpuStall, "R8 no cpu grant while stalled", grantCpu, 0);
    serve(1, 1'b0);
    chk(cpuStall, "R8 slave served during stall", cpuStall, 1);
    busMasterAck = 1'b1;
    @(negedge clk);
    chk(grantCpu && !cpuStall && busHoldReq, "R9 mastership releases stall",
        {grantCpu, cpuStall, busHoldReq}, 5);
    cpuLockReq = 1'b0;
    runCpu(1'b1, 1'b0, 1'b1);
    chk(busHoldReq, "R9 hold kept before unlock", busHoldReq, 1);
    runCpu(1'b1, 1'b1, 1'b0);
    chk(busHoldReq, "R9 hold kept in unlock done phase", busHoldReq, 1);
    @(negedge clk);
    chk(!busHoldReq && !cpuStall, "R9 hold dropped after unlock", busHoldReq, 0);
    busMasterAck = 1'b0;
    expQ.push_back(4);
    tick(4);
    chk(expQ.size() == 0, "R5/R6 all events seen", expQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule